// File: doc/BRIEF.md
# Warm Reset Sequencing Controller

This block orders the steps of a warm reset for a multicore processor subsystem. Software writes a single request strobe once every CPU has been idled. The controller then runs up to three quiesce handshakes: memory controller first, then programmable-logic fabric, then trace unit. Each handshake is skipped when its enable bit is clear. After those it asks the clock controller for a boot-mode change and waits for that controller to acknowledge. The acknowledge is the commit point of the warm reset.

After the commit point the controller holds the system warm reset for a fixed number of cycles. It then releases the module resets and waits for the on-chip RAM to report that loading is done. Next it releases the L2/snoop-control reset, and last the CPU core and core power-on resets. Peripheral resets are raised with the warm reset and stay raised until software clears them through a mask write.

Cold and watchdog reset requests are arbitrated against the warm reset. Before the commit point such a request aborts the warm reset and is forwarded at once. From the commit point on, the request is latched and forwarded only when the warm reset has completed.

Top module: `wrs_ctrl`

## Requirements
- R1: When `rst` is applied, `state_code` is 0 (idle). Every reset output, every request output, `ext_rst_fire` and `warm_done` are 0.
- R2: In idle, a `warm_req_wr` strobe with no cold or watchdog request present starts the sequence. The first stage (a handshake request, or the boot request when no handshake is enabled) is visible on the outputs one cycle later. The values of `hs_en` are captured with the strobe.
- R3: Handshakes run in ascending index order: bit 0 is the memory controller, bit 1 the fabric, bit 2 the trace unit. A leg whose enable bit is 0 is skipped. With all enable bits clear, the sequence goes straight to the boot request.
- R4: Each handshake is level based. `hs_req[i]` stays high until `hs_ack[i]` is sampled high, and falls the cycle after. The next stage starts the cycle after `hs_ack[i]` is sampled low. At most one request output is high at any time.
- R5: `boot_req` follows the last handshake and stays high while `boot_ack` is low. After `boot_ack` is sampled high, the block waits for `boot_ack` to be sampled low.
- R6: A cold or watchdog request sampled in idle or in any state before `boot_ack` is seen prevents or aborts the warm reset. The next cycle shows `state_code` 0, all requests low and `ext_rst_fire` high. `ext_rst_wdog` is 0 for cold and 1 for watchdog, and cold wins when both are present.
- R7: A cold or watchdog request sampled after `boot_ack` has been seen is held and does not raise `ext_rst_fire`. It is forwarded in the cycle that the block returns to idle, with the same encoding and priority as R6.
- R8: After `boot_ack` falls, `sys_warm_rst` is high for exactly `HOLD_CYC` cycles. During that time all bits of `mod_rst`, `l2_rst`, `core_rst` and `core_por_rst` are high.
- R9: After the hold, `sys_warm_rst` and `mod_rst` fall. `l2_rst` stays high until `ram_load_done` is sampled high, and falls one cycle after that.
- R10: `core_rst` and `core_por_rst` fall one cycle after `l2_rst` falls.
- R11: All bits of `per_rst` rise when the hold starts and are still high after completion. A `per_rel_wr` strobe clears the bits set in `per_rel_mask` on the next cycle.
- R12: `state_code` encodes idle=0, handshake request=1, handshake drop=2, boot request=3, boot drop=4, hold=5, RAM wait=6, L2 release=7, finish=8. `warm_done` goes high in the cycle of the return to idle after a completed sequence, stays high, and clears when a new sequence starts.
- R13: A `warm_req_wr` strobe while a sequence is in progress has no effect on the state or on the sequence timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| warm_req_wr | input | 1 | Software warm reset request strobe |
| hs_en | input | 3 | Handshake enables: bit0 memory, bit1 fabric, bit2 trace |
| hs_ack | input | 3 | Handshake acknowledges |
| hs_req | output | 3 | Handshake requests |
| boot_ack | input | 1 | Boot-mode acknowledge from clock controller |
| boot_req | output | 1 | Boot-mode request to clock controller |
| cold_req | input | 1 | Cold reset request |
| wdog_req | input | 1 | Watchdog reset request |
| ram_load_done | input | 1 | On-chip RAM load complete |
| sys_warm_rst | output | 1 | System warm reset |
| mod_rst | output | NMOD | Module resets other than the processor complex |
| l2_rst | output | 1 | L2/snoop-control reset |
| core_rst | output | NCORE | CPU core resets |
| core_por_rst | output | NCORE | CPU core power-on resets |
| per_rel_wr | input | 1 | Peripheral reset release strobe |
| per_rel_mask | input | NPER | Peripheral resets to release |
| per_rst | output | NPER | Peripheral resets |
| ext_rst_fire | output | 1 | One-cycle forward of a cold/watchdog reset |
| ext_rst_wdog | output | 1 | Kind of the last forward: 0 cold, 1 watchdog |
| state_code | output | 4 | Current sequence state |
| warm_done | output | 1 | Sticky completion flag |

## Verification
Every output is either decoded from the state register or held in a register, so each result appears one edge after the input that causes it. The only exceptions are the hold time and the RAM gate. The bench changes inputs 2 ns after a rising edge and reads outputs 2 ns after the next one. The single-cycle offsets of R2, R4, R6, R9, R10 and R11 are therefore checked on the very next sample. An acknowledge responder that echoes the requests fixes each handshake at two cycles. The busy time of a run is then 2·(enabled legs) + HOLD_CYC + 5 cycles, and the bench checks it exactly for all eight enable patterns. It also counts the cycles with `sys_warm_rst` high, checks the order of the handshake requests, and checks the cycle of the held forward against the cycle of the return to idle.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    localparam int HS_LEGS = 3;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_HS_REQ    = 4'd1,
        ST_HS_DROP   = 4'd2,
        ST_BOOT_REQ  = 4'd3,
        ST_BOOT_DROP = 4'd4,
        ST_HOLD      = 4'd5,
        ST_RAM_WAIT  = 4'd6,
        ST_L2_REL    = 4'd7,
        ST_FINISH    = 4'd8
    } wrs_state_e;

    typedef logic [1:0] leg_idx_t;
    localparam leg_idx_t LEG_NONE = 2'd3;

    typedef struct packed {
        logic sys_warm;
        logic modules;
        logic l2;
        logic cores;
    } rst_view_t;

    // lowest enabled leg at or above start, LEG_NONE when none remains
    function automatic leg_idx_t first_leg(input logic [HS_LEGS-1:0] en, input leg_idx_t start);
        leg_idx_t r;
        r = LEG_NONE;
        for (int i = HS_LEGS - 1; i >= 0; i--) begin
            if (en[i] && (i >= int'(start))) r = leg_idx_t'(i);
        end
        return r;
    endfunction

    // states in which a cold or watchdog request may still abort
    function automatic logic is_precommit(input wrs_state_e s);
        return (s == ST_IDLE) || (s == ST_HS_REQ) || (s == ST_HS_DROP) || (s == ST_BOOT_REQ);
    endfunction

    function automatic rst_view_t decode_rst(input wrs_state_e s);
        rst_view_t v;
        v = '0;
        case (s)
            ST_HOLD:     v = '{sys_warm: 1'b1, modules: 1'b1, l2: 1'b1, cores: 1'b1};
            ST_RAM_WAIT: v = '{sys_warm: 1'b0, modules: 1'b0, l2: 1'b1, cores: 1'b1};
            ST_L2_REL:   v = '{sys_warm: 1'b0, modules: 1'b0, l2: 1'b0, cores: 1'b1};
            default:     v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wrs_hold_timer.sv
module wrs_hold_timer #(
    parameter int HOLD_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(HOLD_CYC - 1);
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HOLD_CYC - 1));

endmodule

// File: rtl/wrs_ext_arb.sv
module wrs_ext_arb (
    input  logic clk,
    input  logic rst,
    input  logic cold,
    input  logic wdog,
    input  logic abort_ok,
    input  logic flush,
    output logic fire,
    output logic kind_wdog
);
    logic pend_cold, pend_wdog;
    logic latch_en;

    assign latch_en = !abort_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cold <= 1'b0;
            pend_wdog <= 1'b0;
            fire      <= 1'b0;
            kind_wdog <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (abort_ok && (cold || wdog)) begin
                fire      <= 1'b1;
                kind_wdog <= !cold;
            end else if (latch_en) begin
                if (flush) begin
                    if (pend_cold || pend_wdog || cold || wdog) begin
                        fire      <= 1'b1;
                        kind_wdog <= !(pend_cold || cold);
                    end
                    pend_cold <= 1'b0;
                    pend_wdog <= 1'b0;
                end else begin
                    pend_cold <= pend_cold | cold;
                    pend_wdog <= pend_wdog | wdog;
                end
            end
        end
    end

    assert_abort_fire_R6: assert property (@(posedge clk) disable iff (rst)
        (abort_ok && (cold || wdog)) |=> (fire && (kind_wdog == !$past(cold))));

    assert_hold_pending_R7: assert property (@(posedge clk) disable iff (rst)
        (!abort_ok && !flush) |=> !fire);

endmodule

// File: rtl/wrs_per_bank.sv
module wrs_per_bank #(
    parameter int NPER = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_all,
    input  logic            rel_wr,
    input  logic [NPER-1:0] rel_mask,
    output logic [NPER-1:0] per_rst
);
    always_ff @(posedge clk) begin
        if (rst) begin
            per_rst <= '0;
        end else if (set_all) begin
            per_rst <= '1;
        end else if (rel_wr) begin
            per_rst <= per_rst & ~rel_mask;
        end
    end

    assert_per_set_R11: assert property (@(posedge clk) disable iff (rst)
        set_all |=> (&per_rst));

    assert_per_rel_R11: assert property (@(posedge clk) disable iff (rst)
        (rel_wr && !set_all) |=> ((per_rst & $past(rel_mask)) == '0));

endmodule

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
    import wrs_pkg::*;
#(
    parameter int HOLD_CYC = 256,
    parameter int NCORE    = 4,
    parameter int NMOD     = 8,
    parameter int NPER     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_req_wr,
    input  logic [2:0]       hs_en,
    input  logic [2:0]       hs_ack,
    output logic [2:0]       hs_req,
    input  logic             boot_ack,
    output logic             boot_req,
    input  logic             cold_req,
    input  logic             wdog_req,
    input  logic             ram_load_done,
    output logic             sys_warm_rst,
    output logic [NMOD-1:0]  mod_rst,
    output logic             l2_rst,
    output logic [NCORE-1:0] core_rst,
    output logic [NCORE-1:0] core_por_rst,
    input  logic             per_rel_wr,
    input  logic [NPER-1:0]  per_rel_mask,
    output logic [NPER-1:0]  per_rst,
    output logic             ext_rst_fire,
    output logic             ext_rst_wdog,
    output logic [3:0]       state_code,
    output logic             warm_done
);
    wrs_state_e state, state_n;
    leg_idx_t   leg, leg_n;
    logic [2:0] en_q;
    logic       start, hold_go, expired, ext_hit;
    logic [3:0] ack_ext;
    leg_idx_t   nxt_leg;
    rst_view_t  rv;

    assign ext_hit = cold_req || wdog_req;
    assign ack_ext = {1'b0, hs_ack};

    always_comb begin
        state_n = state;
        leg_n   = leg;
        start   = 1'b0;
        hold_go = 1'b0;
        nxt_leg = LEG_NONE;
        case (state)
            ST_IDLE: begin
                if (warm_req_wr && !ext_hit) begin
                    start   = 1'b1;
                    nxt_leg = first_leg(hs_en, 2'd0);
                    leg_n   = nxt_leg;
                    state_n = (nxt_leg != LEG_NONE) ? ST_HS_REQ : ST_BOOT_REQ;
                end
            end
            ST_HS_REQ: begin
                if (ext_hit)           state_n = ST_IDLE;
                else if (ack_ext[leg]) state_n = ST_HS_DROP;
            end
            ST_HS_DROP: begin
                if (ext_hit) begin
                    state_n = ST_IDLE;
                end else if (!ack_ext[leg]) begin
                    nxt_leg = first_leg(en_q, leg_idx_t'(leg + 2'd1));
                    leg_n   = nxt_leg;
                    state_n = (nxt_leg != LEG_NONE) ? ST_HS_REQ : ST_BOOT_REQ;
                end
            end
            ST_BOOT_REQ: begin
                if (ext_hit)       state_n = ST_IDLE;
                else if (boot_ack) state_n = ST_BOOT_DROP;
            end
            ST_BOOT_DROP: begin
                if (!boot_ack) begin
                    hold_go = 1'b1;
                    state_n = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (expired) state_n = ST_RAM_WAIT;
            end
            ST_RAM_WAIT: begin
                if (ram_load_done) state_n = ST_L2_REL;
            end
            ST_L2_REL: state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            leg       <= LEG_NONE;
            en_q      <= '0;
            warm_done <= 1'b0;
        end else begin
            state <= state_n;
            leg   <= leg_n;
            if (start) begin
                en_q      <= hs_en;
                warm_done <= 1'b0;
            end else if (state == ST_FINISH) begin
                warm_done <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < HS_LEGS; g++) begin : g_leg
        assign hs_req[g] = (state == ST_HS_REQ) && (leg == leg_idx_t'(g));
    end

    assign boot_req   = (state == ST_BOOT_REQ);
    assign state_code = state;

    assign rv           = decode_rst(state);
    assign sys_warm_rst = rv.sys_warm;
    assign mod_rst      = {NMOD{rv.modules}};
    assign l2_rst       = rv.l2;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign core_rst[c]     = rv.cores;
        assign core_por_rst[c] = rv.cores;
    end

    wrs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (hold_go),
        .run     (state == ST_HOLD),
        .expired (expired)
    );

    wrs_ext_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .cold      (cold_req),
        .wdog      (wdog_req),
        .abort_ok  (is_precommit(state)),
        .flush     (state == ST_FINISH),
        .fire      (ext_rst_fire),
        .kind_wdog (ext_rst_wdog)
    );

    wrs_per_bank #(.NPER(NPER)) u_per (
        .clk      (clk),
        .rst      (rst),
        .set_all  (hold_go),
        .rel_wr   (per_rel_wr),
        .rel_mask (per_rel_mask),
        .per_rst  (per_rst)
    );

    assert_req_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({boot_req, hs_req}));

    assert_boot_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BOOT_REQ && !boot_ack && !ext_hit) |=> boot_req);

    assert_warm_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_warm_rst) |-> ($past(state) == ST_BOOT_DROP && !$past(boot_ack)));

    assert_l2_gate_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(l2_rst) |-> $past(ram_load_done));

    assert_core_after_l2_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst[0]) |-> (!l2_rst && $past(!l2_rst)));

    assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !expired) |=> (state == ST_HOLD));

endmodule

// File: tb/sim_wrs_ctrl.sv
module sim_wrs_ctrl;
    localparam int H  = 6;
    localparam int NC = 4;
    localparam int NM = 8;
    localparam int NP = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          warm_req_wr = 1'b0;
    logic [2:0]    hs_en = '0, hs_ack = '0, hs_req;
    logic          boot_ack = 1'b0, boot_req;
    logic          cold_req = 1'b0, wdog_req = 1'b0, ram_load_done = 1'b1;
    logic          sys_warm_rst, l2_rst;
    logic [NM-1:0] mod_rst;
    logic [NC-1:0] core_rst, core_por_rst;
    logic          per_rel_wr = 1'b0;
    logic [NP-1:0] per_rel_mask = '0, per_rst;
    logic          ext_rst_fire, ext_rst_wdog, warm_done;
    logic [3:0]    state_code;

    int  total = 0;
    int  bad = 0;
    bit  auto_ack = 0;

    wrs_ctrl #(.HOLD_CYC(H), .NCORE(NC), .NMOD(NM), .NPER(NP)) u0 (
        .clk(clk), .rst(rst), .warm_req_wr(warm_req_wr), .hs_en(hs_en),
        .hs_ack(hs_ack), .hs_req(hs_req), .boot_ack(boot_ack), .boot_req(boot_req),
        .cold_req(cold_req), .wdog_req(wdog_req), .ram_load_done(ram_load_done),
        .sys_warm_rst(sys_warm_rst), .mod_rst(mod_rst), .l2_rst(l2_rst),
        .core_rst(core_rst), .core_por_rst(core_por_rst), .per_rel_wr(per_rel_wr),
        .per_rel_mask(per_rel_mask), .per_rst(per_rst), .ext_rst_fire(ext_rst_fire),
        .ext_rst_wdog(ext_rst_wdog), .state_code(state_code), .warm_done(warm_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        if (auto_ack) begin
            hs_ack   = hs_req;
            boot_ack = boot_req;
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // full sequence with echoing responder; checks order, timing, hold, release order
    task automatic run_seq(input logic [2:0] en, input bit late_wdog);
        int p, busy, sysn, masks_bad, last_l2, last_core, nobs, obs, expo, fires;
        bit injected;
        logic [2:0] prev;
        p = 0; expo = 0;
        for (int i = 0; i < 3; i++) if (en[i]) begin p++; expo = expo * 4 + i + 1; end
        busy = 0; sysn = 0; masks_bad = 0; last_l2 = -1; last_core = -1;
        nobs = 0; obs = 0; fires = 0; injected = 0; prev = '0;
        hs_en = en; auto_ack = 1; ram_load_done = 1'b1;
        warm_req_wr = 1'b1;
        step();
        warm_req_wr = 1'b0;
        chk("R2 first stage code", state_code, (p == 0) ? 4'd3 : 4'd1);
        chk("R12 done cleared at start", warm_done, 1'b0);
        for (int k = 0; k < 200; k++) begin
            if (state_code == 4'd0) break;
            busy++;
            if (ext_rst_fire) fires++;
            if (hs_req != 3'b000 && prev == 3'b000) begin
                nobs++;
                for (int i = 0; i < 3; i++) if (hs_req[i]) obs = obs * 4 + i + 1;
            end
            prev = hs_req;
            if (sys_warm_rst) begin
                sysn++;
                if (mod_rst != '1 || core_rst != '1 || core_por_rst != '1 || !l2_rst) masks_bad++;
                if (!injected) begin
                    injected = 1;
                    warm_req_wr = 1'b1;
                    if (late_wdog) wdog_req = 1'b1;
                end
            end
            if (l2_rst) last_l2 = k;
            if (core_rst != '0) last_core = k;
            step();
            warm_req_wr = 1'b0;
            wdog_req = 1'b0;
        end
        chk("R3 handshake order", obs, expo);
        chk("R4 R13 busy cycles", busy, 2 * p + H + 5);
        chk("R8 hold length", sysn, H);
        chk("R8 resets high in hold", masks_bad, 0);
        chk("R10 cores one cycle after L2", last_core, last_l2 + 1);
        chk("R7 no early forward", fires, 0);
        chk("R12 done after finish", warm_done, 1'b1);
        chk("R11 peripherals still held", per_rst, {NP{1'b1}});
        chk("R7 held forward at idle", ext_rst_fire, late_wdog);
        if (late_wdog) chk("R7 held kind watchdog", ext_rst_wdog, 1'b1);
        auto_ack = 0; hs_ack = '0; boot_ack = 1'b0;
        step();
        chk("R7 forward is one cycle", ext_rst_fire, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        #3;
        rst = 1'b1;
        repeat (3) step();
        chk("R1 reset state", state_code, 4'd0);
        chk("R1 reset outputs", {sys_warm_rst, mod_rst, l2_rst, core_rst, core_por_rst, per_rst},
            '0);
        chk("R1 reset requests", {hs_req, boot_req, ext_rst_fire, warm_done}, '0);
        rst = 1'b0;
        step();
        chk("R1 idle after reset", state_code, 4'd0);

        // R3 R4 R8 R10: sweep every enable pattern
        for (int e = 0; e < 8; e++) run_seq(3'(e), 1'b0);
        // R7: watchdog sampled during hold is held to the end
        run_seq(3'b101, 1'b1);

        // R11: software release of peripheral resets
        per_rel_wr = 1'b1; per_rel_mask = 4'b0101;
        step();
        per_rel_wr = 1'b0;
        chk("R11 masked release", per_rst, 4'b1010);

        // R6: cold in idle, also blocking a simultaneous warm request
        cold_req = 1'b1; warm_req_wr = 1'b1;
        step();
        cold_req = 1'b0; warm_req_wr = 1'b0;
        chk("R6 idle cold not started", state_code, 4'd0);
        chk("R6 idle cold forwarded", {ext_rst_fire, ext_rst_wdog}, 2'b10);

        // R4 R13 R6: manual handshakes, then cold abort in second leg
        hs_en = 3'b111; warm_req_wr = 1'b1;
        step();
        warm_req_wr = 1'b0;
        chk("R2 memory leg request", {state_code, hs_req}, {4'd1, 3'b001});
        warm_req_wr = 1'b1;
        step();
        warm_req_wr = 1'b0;
        chk("R13 busy request ignored", {state_code, hs_req}, {4'd1, 3'b001});
        hs_ack = 3'b001;
        step();
        chk("R4 request drops after ack", {state_code, hs_req}, {4'd2, 3'b000});
        step();
        chk("R4 waits for ack low", state_code, 4'd2);
        hs_ack = 3'b000;
        step();
        chk("R3 fabric leg next", {state_code, hs_req}, {4'd1, 3'b010});
        cold_req = 1'b1;
        step();
        cold_req = 1'b0;
        chk("R6 cold abort", {state_code, hs_req, ext_rst_fire, ext_rst_wdog},
            {4'd0, 3'b000, 1'b1, 1'b0});
        step();
        chk("R6 forward one cycle", ext_rst_fire, 1'b0);

        // R5 R6: boot stall then watchdog abort
        hs_en = 3'b000; warm_req_wr = 1'b1;
        step();
        warm_req_wr = 1'b0;
        chk("R5 boot request", {state_code, boot_req}, {4'd3, 1'b1});
        step(); step();
        chk("R5 stall without ack", {state_code, boot_req}, {4'd3, 1'b1});
        wdog_req = 1'b1;
        step();
        wdog_req = 1'b0;
        chk("R6 watchdog abort", {state_code, boot_req, ext_rst_fire, ext_rst_wdog},
            {4'd0, 1'b0, 1'b1, 1'b1});

        // R6: cold wins over watchdog
        warm_req_wr = 1'b1;
        step();
        warm_req_wr = 1'b0;
        cold_req = 1'b1; wdog_req = 1'b1;
        step();
        cold_req = 1'b0; wdog_req = 1'b0;
        chk("R6 cold priority", {ext_rst_fire, ext_rst_wdog}, 2'b10);

        // R5 R7: cold after boot ack is held; R9 RAM gate
        warm_req_wr = 1'b1;
        step();
        warm_req_wr = 1'b0;
        boot_ack = 1'b1;
        step();
        chk("R5 boot drop waits", {state_code, boot_req}, {4'd4, 1'b0});
        cold_req = 1'b1;
        step();
        cold_req = 1'b0;
        chk("R7 cold held after commit", {state_code, ext_rst_fire}, {4'd4, 1'b0});
        boot_ack = 1'b0; ram_load_done = 1'b0;
        step();
        chk("R8 hold begins", {state_code, sys_warm_rst}, {4'd5, 1'b1});
        for (int k = 0; k < 50; k++) begin
            if (state_code == 4'd6) break;
            step();
        end
        for (int k = 0; k < 4; k++) begin
            chk("R9 L2 held until RAM done", {state_code, sys_warm_rst, mod_rst, l2_rst, core_rst},
                {4'd6, 1'b0, {NM{1'b0}}, 1'b1, {NC{1'b1}}});
            step();
        end
        ram_load_done = 1'b1;
        step();
        chk("R9 L2 released", {state_code, l2_rst, core_rst}, {4'd7, 1'b0, {NC{1'b1}}});
        step();
        chk("R10 cores released", {state_code, core_rst, core_por_rst}, {4'd8, {2*NC{1'b0}}});
        step();
        chk("R7 held cold forwarded", {state_code, ext_rst_fire, ext_rst_wdog, warm_done},
            {4'd0, 1'b1, 1'b0, 1'b1});

        summary();
    end
endmodule